// File: doc/BRIEF.md
# Interrupt routing multiplexer

This block sits between a set of peripheral request lines and the two interrupt inputs of a small controller CPU: a normal interrupt (IRQ) and a fast interrupt (FIRQ). The peripherals are a host-bus interface, which raises a data request and a general interrupt, and a floppy controller, which raises its own data request and interrupt. There is also the drive's index pulse and a DMA enable level. Firmware picks one of four routings by writing a 2-bit select field into a routing control byte. Bit 2 of that byte is an active-low enable that silences both CPU inputs when it is high.

The index pulse is not routed as a level. Its rising edge sets a sticky flag, and only that flag can reach FIRQ. Firmware clears the flag by writing a second control byte with bit 2 at 0. Both CPU interrupt outputs come from flip-flops, so each output reflects the routing state and the request lines one clock after they are sampled.

Top module: `irq_route_mux`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs are 0 after that edge. Reset also sets the select field to 0, puts the enable in its disabled state and clears the index flag, so interrupts stay off until the routing byte is written.
- R2: With select 0 and interrupts enabled, `cpu_irq` follows `host_dreq` and `cpu_firq` follows `host_int`.
- R3: With select 1 and interrupts enabled, `cpu_irq` is 0 and `cpu_firq` follows the index flag.
- R4: With select 2 and interrupts enabled, `cpu_irq` is `host_dreq AND dma_en`, and `cpu_firq` is `flp_int OR host_int`.
- R5: With select 3 and interrupts enabled, `cpu_irq` follows `flp_dreq` and `cpu_firq` follows `flp_int`.
- R6: A write to the routing byte (`route_wr`) loads the select from `wr_data[1:0]` and the enable from `wr_data[2]`. While the stored enable bit is 1, both outputs are 0 whatever the select and the request lines are.
- R7: A 0-to-1 change of `flp_index` between two consecutive clock edges sets the index flag. If `flp_index` stays high, the flag is not set again after it has been cleared.
- R8: A write to the clear byte (`clr_wr`) with `wr_data[2]` at 0 clears the index flag. The same write with `wr_data[2]` at 1 leaves the flag unchanged. When a rising index edge lands in the same cycle as a clearing write, the flag ends up set.
- R9: Each output is registered. It reflects the control state and request lines that were sampled at the previous clock edge, so a one-cycle request pulse produces a one-cycle output pulse delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_wr | input | 1 | Write strobe for the routing control byte |
| clr_wr | input | 1 | Write strobe for the index-clear byte |
| wr_data | input | DATA_W | Write data shared by both control bytes |
| host_dreq | input | 1 | Host-bus interface data request |
| host_int | input | 1 | Host-bus interface interrupt |
| flp_dreq | input | 1 | Floppy controller data request |
| flp_int | input | 1 | Floppy controller interrupt |
| flp_index | input | 1 | Floppy index pulse |
| dma_en | input | 1 | DMA enable level; gates the host data request in select 2 |
| cpu_irq | output | 1 | Registered normal interrupt request to the CPU |
| cpu_firq | output | 1 | Registered fast interrupt request to the CPU |

## Verification
The hardest case to reach is the index flag's edge behaviour. A rising index edge that coincides with a clearing write must leave the flag set. A clear issued while the index line is still held high must keep the flag at 0. The flag is only visible when the routing points FIRQ at it, so the stimulus first selects routing 1 with interrupts enabled. It then raises the index line, holds it high across a clearing write and a non-clearing write, and finally drops the line and raises it again in the very cycle of another clearing write, watching `cpu_firq` one cycle after each step.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Width of the routing select field.
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        ROUTE_HOST   = 2'd0,
        ROUTE_INDEX  = 2'd1,
        ROUTE_DMA    = 2'd2,
        ROUTE_FLOPPY = 2'd3
    } route_sel_e;

    // Peripheral request lines as seen by the routing table.
    typedef struct packed {
        logic host_dreq;
        logic host_int;
        logic flp_dreq;
        logic flp_int;
        logic dma_en;
    } req_lines_t;

    // Pair of CPU interrupt levels.
    typedef struct packed {
        logic irq;
        logic firq;
    } cpu_int_t;

    localparam cpu_int_t INT_NONE = '{irq: 1'b0, firq: 1'b0};

    // Four-way routing of the request lines onto the two CPU inputs.
    function automatic cpu_int_t route_lookup(
        input route_sel_e sel,
        input req_lines_t req,
        input logic       idx_flag
    );
        cpu_int_t r;
        r = INT_NONE;
        case (sel)
            ROUTE_HOST: begin
                r.irq  = req.host_dreq;
                r.firq = req.host_int;
            end
            ROUTE_INDEX: begin
                r.irq  = 1'b0;
                r.firq = idx_flag;
            end
            ROUTE_DMA: begin
                r.irq  = req.host_dreq & req.dma_en;
                r.firq = req.flp_int | req.host_int;
            end
            ROUTE_FLOPPY: begin
                r.irq  = req.flp_dreq;
                r.firq = req.flp_int;
            end
            default: r = INT_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             route_wr,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             ena_n_in,
    output route_sel_e       sel_q,
    output logic             ena_n_q
);

    // Routing control byte: select field plus active-low enable.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= ROUTE_HOST;
            ena_n_q <= 1'b1;
        end else if (route_wr) begin
            sel_q   <= route_sel_e'(sel_in);
            ena_n_q <= ena_n_in;
        end
    end

endmodule

// File: rtl/irq_route_index.sv
module irq_route_index (
    input  logic clk,
    input  logic rst,
    input  logic flp_index,
    input  logic clr_wr,
    input  logic clr_n_in,
    output logic latched
);

    logic prev_q;
    logic rise;

    // Previous index level; tracks the line through reset so a level
    // already high when reset ends does not count as an edge.
    always_ff @(posedge clk) begin
        prev_q <= flp_index;
    end

    assign rise = flp_index & ~prev_q;

    // Sticky flag: a new edge wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= 1'b0;
        end else if (rise) begin
            latched <= 1'b1;
        end else if (clr_wr && !clr_n_in) begin
            latched <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  route_sel_e sel,
    input  logic       ena_n,
    input  req_lines_t req,
    input  logic       idx_flag,
    output logic       cpu_irq,
    output logic       cpu_firq
);

    cpu_int_t next_int;
    cpu_int_t cur_q;

    always_comb begin
        if (ena_n) begin
            next_int = INT_NONE;
        end else begin
            next_int = route_lookup(sel, req, idx_flag);
        end
    end

    // Output levels are updated only when the routed value moves.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= INT_NONE;
        end else if (next_int != cur_q) begin
            cur_q <= next_int;
        end
    end

    assign cpu_irq  = cur_q.irq;
    assign cpu_firq = cur_q.firq;

endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux
    import irq_route_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SEL_LSB   = 0,
    parameter int ENA_N_BIT = 2,
    parameter int CLR_N_BIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              route_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              host_dreq,
    input  logic              host_int,
    input  logic              flp_dreq,
    input  logic              flp_int,
    input  logic              flp_index,
    input  logic              dma_en,
    output logic              cpu_irq,
    output logic              cpu_firq
);

    localparam logic [DATA_W-1:0] SEL_MASK  = DATA_W'(((1 << SEL_W) - 1) << SEL_LSB);
    localparam logic [DATA_W-1:0] ENA_MASK  = DATA_W'(1 << ENA_N_BIT);
    localparam logic [DATA_W-1:0] CLR_MASK  = DATA_W'(1 << CLR_N_BIT);
    localparam logic [DATA_W-1:0] USED_MASK = SEL_MASK | ENA_MASK | CLR_MASK;

    route_sel_e sel_q;
    logic       ena_n_q;
    logic       idx_latched;
    req_lines_t req;
    logic       data_unused;

    // Bits of the control bytes that carry no function.
    assign data_unused = ^(wr_data & ~USED_MASK);

    assign req = '{host_dreq: host_dreq, host_int: host_int,
                   flp_dreq: flp_dreq, flp_int: flp_int, dma_en: dma_en};

    irq_route_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .route_wr (route_wr),
        .sel_in   (wr_data[SEL_LSB +: SEL_W]),
        .ena_n_in (wr_data[ENA_N_BIT]),
        .sel_q    (sel_q),
        .ena_n_q  (ena_n_q)
    );

    irq_route_index u_index (
        .clk       (clk),
        .rst       (rst),
        .flp_index (flp_index),
        .clr_wr    (clr_wr),
        .clr_n_in  (wr_data[CLR_N_BIT]),
        .latched   (idx_latched)
    );

    irq_route_table u_table (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel_q),
        .ena_n    (ena_n_q),
        .req      (req),
        .idx_flag (idx_latched),
        .cpu_irq  (cpu_irq),
        .cpu_firq (cpu_firq)
    );

endmodule

// File: rtl/irq_route_mux_chk.sv
module irq_route_mux_chk (
    input logic       clk,
    input logic       rst,
    input logic       clr_wr,
    input logic       clr_bit,
    input logic       flp_index,
    input logic       host_dreq,
    input logic       host_int,
    input logic       flp_dreq,
    input logic       flp_int,
    input logic       dma_en,
    input logic [1:0] sel_q,
    input logic       ena_n_q,
    input logic       idx_latched,
    input logic       cpu_irq,
    input logic       cpu_firq
);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!cpu_irq && !cpu_firq));

    // R6
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        ena_n_q |=> (!cpu_irq && !cpu_firq));

    // R2
    a_r2_host_route: assert property (@(posedge clk) disable iff (rst)
        (!ena_n_q && sel_q == 2'd0) |=>
        (cpu_irq == $past(host_dreq) && cpu_firq == $past(host_int)));

    // R3
    a_r3_index_route: assert property (@(posedge clk) disable iff (rst)
        (!ena_n_q && sel_q == 2'd1) |=>
        (!cpu_irq && cpu_firq == $past(idx_latched)));

    // R4
    a_r4_dma_route: assert property (@(posedge clk) disable iff (rst)
        (!ena_n_q && sel_q == 2'd2) |=>
        (cpu_irq == $past(host_dreq && dma_en) &&
         cpu_firq == $past(host_int || flp_int)));

    // R5
    a_r5_floppy_route: assert property (@(posedge clk) disable iff (rst)
        (!ena_n_q && sel_q == 2'd3) |=>
        (cpu_irq == $past(flp_dreq) && cpu_firq == $past(flp_int)));

    // R7
    a_r7_edge_sets: assert property (@(posedge clk) disable iff (rst)
        $rose(flp_index) |=> idx_latched);

    // R8
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !clr_bit && !$rose(flp_index)) |=> !idx_latched);

    // R8
    a_r8_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (idx_latched && !(clr_wr && !clr_bit)) |=> idx_latched);

endmodule

bind irq_route_mux irq_route_mux_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_wr      (clr_wr),
    .clr_bit     (wr_data[CLR_N_BIT]),
    .flp_index   (flp_index),
    .host_dreq   (host_dreq),
    .host_int    (host_int),
    .flp_dreq    (flp_dreq),
    .flp_int     (flp_int),
    .dma_en      (dma_en),
    .sel_q       (sel_q),
    .ena_n_q     (ena_n_q),
    .idx_latched (idx_latched),
    .cpu_irq     (cpu_irq),
    .cpu_firq    (cpu_firq)
);

// File: tb/irq_route_mux_bench.sv
module irq_route_mux_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       route_wr = 1'b0;
    logic       clr_wr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       host_dreq = 1'b0;
    logic       host_int = 1'b0;
    logic       flp_dreq = 1'b0;
    logic       flp_int = 1'b0;
    logic       flp_index = 1'b0;
    logic       dma_en = 1'b0;
    logic       cpu_irq;
    logic       cpu_firq;

    always #5 clk = ~clk;

    irq_route_mux u_irq_route_mux (
        .clk       (clk),
        .rst       (rst),
        .route_wr  (route_wr),
        .clr_wr    (clr_wr),
        .wr_data   (wr_data),
        .host_dreq (host_dreq),
        .host_int  (host_int),
        .flp_dreq  (flp_dreq),
        .flp_int   (flp_int),
        .flp_index (flp_index),
        .dma_en    (dma_en),
        .cpu_irq   (cpu_irq),
        .cpu_firq  (cpu_firq)
    );

    typedef struct {
        logic  irq;
        logic  firq;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;

    // Reference state built from the requirements.
    logic [1:0] m_sel   = 2'd0;
    logic       m_ena_n = 1'b1;
    logic       m_flag  = 1'b0;
    logic       m_prev  = 1'b0;

    // Driver: one call per clock edge; pushes the value expected after it.
    task automatic cyc(input string tag);
        exp_t e;
        e.tag  = tag;
        e.irq  = 1'b0;
        e.firq = 1'b0;
        if (!rst && !m_ena_n) begin
            case (m_sel)
                2'd0: begin e.irq = host_dreq;          e.firq = host_int; end
                2'd1: begin e.irq = 1'b0;               e.firq = m_flag; end
                2'd2: begin e.irq = host_dreq & dma_en; e.firq = flp_int | host_int; end
                default: begin e.irq = flp_dreq;        e.firq = flp_int; end
            endcase
        end
        q.push_back(e);
        if (rst) begin
            m_sel = 2'd0; m_ena_n = 1'b1; m_flag = 1'b0;
        end else begin
            if (route_wr) begin
                m_sel = wr_data[1:0]; m_ena_n = wr_data[2];
            end
            if (flp_index && !m_prev) m_flag = 1'b1;
            else if (clr_wr && !wr_data[2]) m_flag = 1'b0;
        end
        m_prev = flp_index;
        @(negedge clk);
    endtask

    task automatic wr_route(input logic [7:0] d, input string tag);
        route_wr = 1'b1; wr_data = d;
        cyc(tag);
        route_wr = 1'b0;
    endtask

    task automatic wr_clr(input logic [7:0] d, input string tag);
        clr_wr = 1'b1; wr_data = d;
        cyc(tag);
        clr_wr = 1'b0;
    endtask

    // Monitor: compares each edge's result against the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (cpu_irq !== e.irq || cpu_firq !== e.firq) begin
                    n_fails++;
                    $display("FAIL %s: irq/firq got %b/%b expected %b/%b at %0t",
                             e.tag, cpu_irq, cpu_firq, e.irq, e.firq, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet during reset even with requests up
        host_dreq = 1'b1; host_int = 1'b1;
        repeat (3) cyc("R1");
        rst = 1'b0;
        // R1/R6: disabled after reset, so requests do not pass
        repeat (2) cyc("R1_disabled");

        // R2: enable with select 0
        wr_route(8'h00, "R6_write");
        cyc("R2");
        host_dreq = 1'b0; cyc("R2");
        host_int = 1'b0; host_dreq = 1'b1; cyc("R2");
        host_dreq = 1'b0; cyc("R2");
        flp_dreq = 1'b1; flp_int = 1'b1; cyc("R2_other_lines");
        flp_dreq = 1'b0; flp_int = 1'b0;
        // R9: single-cycle pulses come out delayed by one edge
        host_int = 1'b1; cyc("R9");
        host_int = 1'b0; cyc("R9");
        cyc("R9");

        // R3/R7/R8: index flag through select 1
        wr_route(8'h01, "R3_write");
        host_dreq = 1'b1; cyc("R3_irq_low");
        host_dreq = 1'b0;
        flp_index = 1'b1; cyc("R7_rise");
        cyc("R7_flag");
        cyc("R3_flag");
        wr_clr(8'h04, "R8_no_clear");
        cyc("R8_still_set");
        wr_clr(8'h00, "R8_clear");
        cyc("R7_held_high_no_reset");
        cyc("R7_held_high_no_reset");
        flp_index = 1'b0; cyc("R7_fall");
        cyc("R7_fall");
        flp_index = 1'b1; clr_wr = 1'b1; wr_data = 8'h00;
        cyc("R8_edge_and_clear");
        clr_wr = 1'b0;
        cyc("R8_edge_wins");
        flp_index = 1'b0;
        wr_clr(8'hFB, "R8_clear");
        cyc("R8_cleared");

        // R4: DMA-gated IRQ and OR-combined FIRQ
        wr_route(8'h02, "R4_write");
        host_dreq = 1'b1; dma_en = 1'b0; cyc("R4_dma_off");
        dma_en = 1'b1; cyc("R4_dma_on");
        host_dreq = 1'b0; cyc("R4");
        flp_int = 1'b1; cyc("R4_flp_int");
        flp_int = 1'b0; host_int = 1'b1; cyc("R4_host_int");
        flp_int = 1'b1; cyc("R4_both");
        host_int = 1'b0; flp_int = 1'b0; dma_en = 1'b0; cyc("R4");
        cyc("R4_quiet");

        // R5: floppy routing
        wr_route(8'h03, "R5_write");
        flp_dreq = 1'b1; host_dreq = 1'b1; cyc("R5");
        flp_int = 1'b1; flp_dreq = 1'b0; cyc("R5");
        host_int = 1'b1; flp_int = 1'b0; cyc("R5_host_ignored");
        flp_dreq = 1'b1; flp_int = 1'b1; cyc("R5");

        // R6: enable bit high forces both low
        wr_route(8'h07, "R6_disable");
        cyc("R6");
        cyc("R6");
        wr_route(8'h03, "R6_reenable");
        cyc("R6_back_on");

        // R1: reset mid-run clears select, enable and flag
        flp_index = 1'b1; cyc("R7_rise");
        flp_index = 1'b0;
        rst = 1'b1; cyc("R1");
        cyc("R1");
        rst = 1'b0;
        cyc("R1_disabled");
        wr_route(8'h01, "R1_write");
        cyc("R1_flag_cleared");
        host_dreq = 1'b0; host_int = 1'b0; flp_dreq = 1'b0; flp_int = 1'b0;
        wr_route(8'h00, "R1_write");
        cyc("R2_after_reset");

        while (q.size() > 0) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule